// File: doc/BRIEF.md
# Two-Stage Classification Lookup Sequencer

This block schedules the off-chip reads of a two-phase packet classifier. For each accepted packet, the first phase reads one prefix-match entry for each of four header fields from a dedicated prefix memory. The second phase then reads that packet's candidate rules from a separate rule memory. Both memories return two 36-bit words per clock, so every read command asks for one 72-bit burst. A prefix entry of `b` bits therefore costs `ceil(b/72)` bursts. A rule is 144 bits and always costs two bursts.

The two phases form a pipeline. While the rule phase reads the rules of one packet, the prefix phase already reads the entries of the next packet. With every port ready, a new packet therefore completes every `max(4*ceil(b/72), 2p)` cycles. A packet with no candidate rules bypasses the rule reads. Completion is reported in arrival order, with the packet's tag. The entry width `b` is sampled once, shortly after reset is released.

Top module: `cls_lookup_seq`

## Requirements
- R1: The entry width `cfg_entry_bits` (1 to 288) is captured once after reset and sets the burst count per field, `nb = ceil(b/72)`. Later changes of `cfg_entry_bits` have no effect until the next reset.
- R2: For each packet the prefix port issues exactly `4*nb` bursts, all tagged with the packet's tag. The field number `lpm_cmd_field` runs 0,1,2,3. Within each field, the beat number `lpm_cmd_beat` runs 0 to `nb-1`.
- R3: For a packet with `p` rules the rule port issues exactly `2p` bursts, all tagged with the packet's tag. `rule_cmd_index` runs 0 to `p-1`, and `rule_cmd_half` runs 0 then 1 for each rule. No rule burst is issued when `p = 0`.
- R4: With all ready inputs held high and back-to-back requests of equal `p`, consecutive completions are spaced exactly `max(4*nb, 2p)` cycles apart.
- R5: On an idle block with all ready inputs high, `done_valid` is first seen `4*nb + 2p + 1` cycles after the request handshake. This is also the value when `p = 0`, so such a packet finishes right after its prefix reads.
- R6: Completions appear in the order the requests were accepted, and `done_tag` equals the accepted `req_tag`.
- R7: While `done_valid` is high and `done_ready` is low, `done_valid` stays high and `done_tag` holds. The last rule burst of a packet is not issued while the completion slot is occupied.
- R8: While a command is valid and its ready is low, the command stays valid and its field, beat, index and tag hold.
- R9: While reset is asserted, `req_ready`, both command valids and `done_valid` are low. `req_ready` also stays low in the first cycle after release and is high by the fourth cycle on an idle block.
- R10: A new request is accepted only while the prefix phase is empty or is handing its packet to the rule phase in that same cycle. A finished prefix phase holds its packet until the rule phase is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_entry_bits | input | 9 | Prefix entry width in bits, captured after reset |
| req_valid | input | 1 | Packet request valid |
| req_ready | output | 1 | Packet request accepted when high with valid |
| req_tag | input | 8 | Packet tag |
| req_rule_cnt | input | 4 | Number of candidate rules p (0 to 8) |
| lpm_cmd_valid | output | 1 | Prefix memory burst command valid |
| lpm_cmd_ready | input | 1 | Prefix memory accepts a command |
| lpm_cmd_field | output | 2 | Header field being read |
| lpm_cmd_beat | output | 2 | Burst number within the field's entry |
| lpm_cmd_tag | output | 8 | Tag of the packet being read |
| rule_cmd_valid | output | 1 | Rule memory burst command valid |
| rule_cmd_ready | input | 1 | Rule memory accepts a command |
| rule_cmd_index | output | 4 | Rule number within the packet |
| rule_cmd_half | output | 1 | First (0) or second (1) burst of the rule |
| rule_cmd_tag | output | 8 | Tag of the packet being read |
| done_valid | output | 1 | Packet completion valid |
| done_ready | input | 1 | Completion consumer ready |
| done_tag | output | 8 | Tag of the completed packet |

## Verification
The assertions assume that the request and the completion consumer obey valid/ready rules. A request must not be withdrawn, and its fields must not change, while it waits. `req_rule_cnt` must not exceed 8, and `cfg_entry_bits` must stay within 1 to 288 until the block has captured it. The stimulus holds each request unchanged until the handshake and draws rule counts only from 0 to 8. It sets the width before reset release and changes it only after the capture, to show that the change is ignored. Backpressure is random on all three ready inputs. Tags in flight are always unique, because at most three packets are inside the block at once.

// File: rtl/cls_seq_pkg.sv
package cls_seq_pkg;
  typedef enum logic [1:0] {
    S1_IDLE = 2'd0,
    S1_RUN  = 2'd1,
    S1_HOLD = 2'd2
  } s1_state_e;
endpackage

// File: rtl/cls_seq_cfg.sv
module cls_seq_cfg #(
  parameter int CFG_W      = 9,
  parameter int BURST_BITS = 72,
  parameter int MAX_BEATS  = 4,
  parameter int NB_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_bits,
  output logic [NB_W-1:0]  nb,
  output logic             cfg_ok
);
  localparam int SUM_W = CFG_W + 1;

  logic [SUM_W-1:0] rounded;
  logic [NB_W-1:0]  nb_d, nb_q;
  logic             ok_q;

  always_comb begin
    rounded = ({1'b0, cfg_bits} + SUM_W'(BURST_BITS - 1)) / SUM_W'(BURST_BITS);
    if (rounded == '0)
      nb_d = NB_W'(1);
    else if (rounded > SUM_W'(MAX_BEATS))
      nb_d = NB_W'(MAX_BEATS);
    else
      nb_d = NB_W'(rounded);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
      nb_q <= NB_W'(1);
    end else if (!ok_q) begin
      ok_q <= 1'b1;
      nb_q <= nb_d;
    end
  end

  assign nb     = nb_q;
  assign cfg_ok = ok_q;

  // R1
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> (ok_q && $stable(nb_q)));
endmodule

// File: rtl/cls_seq_lpm_stage.sv
module cls_seq_lpm_stage
  import cls_seq_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 4,
  parameter int FIELDS  = 4,
  parameter int FIELD_W = 2,
  parameter int BEAT_W  = 2,
  parameter int NB_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_ok,
  input  logic [NB_W-1:0]    nb,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [CNT_W-1:0]   req_cnt,
  output logic               lpm_valid,
  input  logic               lpm_ready,
  output logic [FIELD_W-1:0] lpm_field,
  output logic [BEAT_W-1:0]  lpm_beat,
  output logic [TAG_W-1:0]   lpm_tag,
  output logic               avail,
  output logic [TAG_W-1:0]   out_tag,
  output logic [CNT_W-1:0]   out_cnt,
  input  logic               take
);
  s1_state_e          state_q, state_d;
  logic [FIELD_W-1:0] field_q, field_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               fire, beat_last, last, req_fire;

  always_comb begin
    fire      = lpm_valid && lpm_ready;
    beat_last = (NB_W'(beat_q) == (nb - NB_W'(1)));
    last      = fire && beat_last && (field_q == FIELD_W'(FIELDS - 1));
    avail     = (state_q == S1_HOLD) || last;
    req_ready = cfg_ok && ((state_q == S1_IDLE) || (avail && take));
    req_fire  = req_valid && req_ready;

    state_d = state_q;
    field_d = field_q;
    beat_d  = beat_q;
    tag_d   = tag_q;
    cnt_d   = cnt_q;
    if (req_fire) begin
      state_d = S1_RUN;
      field_d = '0;
      beat_d  = '0;
      tag_d   = req_tag;
      cnt_d   = req_cnt;
    end else if (avail && take) begin
      state_d = S1_IDLE;
    end else if (last) begin
      state_d = S1_HOLD;
    end else if (fire) begin
      if (beat_last) begin
        beat_d  = '0;
        field_d = field_q + FIELD_W'(1);
      end else begin
        beat_d  = beat_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S1_IDLE;
      field_q <= '0;
      beat_q  <= '0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      field_q <= field_d;
      beat_q  <= beat_d;
      tag_q   <= tag_d;
      cnt_q   <= cnt_d;
    end
  end

  assign lpm_valid = (state_q == S1_RUN);
  assign lpm_field = field_q;
  assign lpm_beat  = beat_q;
  assign lpm_tag   = tag_q;
  assign out_tag   = tag_q;
  assign out_cnt   = cnt_q;

  // R8
  lpm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_valid && !lpm_ready) |=>
      (lpm_valid && $stable(lpm_field) && $stable(lpm_beat) && $stable(lpm_tag)));

  // R2
  lpm_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_valid |-> (NB_W'(lpm_beat) < nb));

  // R10
  s1_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S1_HOLD) && !take) |=> ((state_q == S1_HOLD) && $stable(tag_q)));
endmodule

// File: rtl/cls_seq_rule_stage.sv
module cls_seq_rule_stage #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avail,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [CNT_W-1:0] in_cnt,
  output logic             take,
  input  logic             done_free,
  output logic             rule_valid,
  input  logic             rule_ready,
  output logic [CNT_W-1:0] rule_idx,
  output logic             rule_half,
  output logic [TAG_W-1:0] rule_tag,
  output logic             done_set,
  output logic [TAG_W-1:0] done_tag_d
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] idx_q, idx_d, cnt_q, cnt_d;
  logic             half_q, half_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             last_beat, fire, last_fire, empty_pkt;

  always_comb begin
    last_beat  = half_q && (idx_q == cnt_q - CNT_W'(1));
    rule_valid = busy_q && !(last_beat && !done_free);
    fire       = rule_valid && rule_ready;
    last_fire  = fire && last_beat;
    empty_pkt  = (in_cnt == '0);
    take       = avail && (empty_pkt ? (!busy_q && done_free) : (!busy_q || last_fire));
    done_set   = last_fire || (take && empty_pkt);
    done_tag_d = last_fire ? tag_q : in_tag;

    busy_d = busy_q;
    idx_d  = idx_q;
    half_d = half_q;
    tag_d  = tag_q;
    cnt_d  = cnt_q;
    if (take && !empty_pkt) begin
      busy_d = 1'b1;
      idx_d  = '0;
      half_d = 1'b0;
      tag_d  = in_tag;
      cnt_d  = in_cnt;
    end else if (last_fire) begin
      busy_d = 1'b0;
    end else if (fire) begin
      if (half_q) begin
        half_d = 1'b0;
        idx_d  = idx_q + CNT_W'(1);
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      half_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      half_q <= half_d;
      tag_q  <= tag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rule_idx  = idx_q;
  assign rule_half = half_q;
  assign rule_tag  = tag_q;

  // R3
  rule_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule_valid |-> (rule_idx < cnt_q));

  // R8
  rule_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_valid && !rule_ready) |=>
      (rule_valid && $stable(rule_idx) && $stable(rule_half) && $stable(rule_tag)));

  // R7
  slot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_free |-> !last_fire);
endmodule

// File: rtl/cls_seq_done.sv
module cls_seq_done #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_set,
  input  logic [TAG_W-1:0] done_tag_d,
  output logic             done_free,
  output logic             done_valid,
  input  logic             done_ready,
  output logic [TAG_W-1:0] done_tag
);
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    done_free = !vld_q || done_ready;
    if (done_set)
      vld_d = 1'b1;
    else if (done_ready)
      vld_d = 1'b0;
    else
      vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (done_set) tag_q <= done_tag_d;
    end
  end

  assign done_valid = vld_q;
  assign done_tag   = tag_q;

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> (done_valid && $stable(done_tag)));
endmodule

// File: rtl/cls_lookup_seq.sv
module cls_lookup_seq #(
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 4,
  parameter int CFG_W      = 9,
  parameter int BURST_BITS = 72,
  parameter int FIELDS     = 4,
  parameter int MAX_BEATS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CFG_W-1:0]            cfg_entry_bits,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [TAG_W-1:0]            req_tag,
  input  logic [CNT_W-1:0]            req_rule_cnt,
  output logic                        lpm_cmd_valid,
  input  logic                        lpm_cmd_ready,
  output logic [$clog2(FIELDS)-1:0]   lpm_cmd_field,
  output logic [$clog2(MAX_BEATS)-1:0] lpm_cmd_beat,
  output logic [TAG_W-1:0]            lpm_cmd_tag,
  output logic                        rule_cmd_valid,
  input  logic                        rule_cmd_ready,
  output logic [CNT_W-1:0]            rule_cmd_index,
  output logic                        rule_cmd_half,
  output logic [TAG_W-1:0]            rule_cmd_tag,
  output logic                        done_valid,
  input  logic                        done_ready,
  output logic [TAG_W-1:0]            done_tag
);
  localparam int FIELD_W = $clog2(FIELDS);
  localparam int BEAT_W  = $clog2(MAX_BEATS);
  localparam int NB_W    = $clog2(MAX_BEATS + 1);

  logic             sync_a_q, sync_b_q;
  logic             rst_int_n;
  logic [NB_W-1:0]  nb;
  logic             cfg_ok;
  logic             avail, take, done_free, done_set;
  logic [TAG_W-1:0] s1_tag, done_tag_d;
  logic [CNT_W-1:0] s1_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a_q <= 1'b0;
      sync_b_q <= 1'b0;
    end else begin
      sync_a_q <= 1'b1;
      sync_b_q <= sync_a_q;
    end
  end
  assign rst_int_n = sync_b_q;

  cls_seq_cfg #(.CFG_W(CFG_W), .BURST_BITS(BURST_BITS), .MAX_BEATS(MAX_BEATS), .NB_W(NB_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_bits(cfg_entry_bits), .nb(nb), .cfg_ok(cfg_ok));

  cls_seq_lpm_stage #(.TAG_W(TAG_W), .CNT_W(CNT_W), .FIELDS(FIELDS), .FIELD_W(FIELD_W),
                      .BEAT_W(BEAT_W), .NB_W(NB_W)) u_lpm (
    .clk(clk), .rst_n(rst_int_n), .cfg_ok(cfg_ok), .nb(nb),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_cnt(req_rule_cnt),
    .lpm_valid(lpm_cmd_valid), .lpm_ready(lpm_cmd_ready), .lpm_field(lpm_cmd_field),
    .lpm_beat(lpm_cmd_beat), .lpm_tag(lpm_cmd_tag),
    .avail(avail), .out_tag(s1_tag), .out_cnt(s1_cnt), .take(take));

  cls_seq_rule_stage #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_rule (
    .clk(clk), .rst_n(rst_int_n), .avail(avail), .in_tag(s1_tag), .in_cnt(s1_cnt),
    .take(take), .done_free(done_free),
    .rule_valid(rule_cmd_valid), .rule_ready(rule_cmd_ready), .rule_idx(rule_cmd_index),
    .rule_half(rule_cmd_half), .rule_tag(rule_cmd_tag),
    .done_set(done_set), .done_tag_d(done_tag_d));

  cls_seq_done #(.TAG_W(TAG_W)) u_done (
    .clk(clk), .rst_n(rst_int_n), .done_set(done_set), .done_tag_d(done_tag_d),
    .done_free(done_free), .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!req_ready && !lpm_cmd_valid && !rule_cmd_valid && !done_valid));
endmodule

// File: tb/sim_cls_lookup_seq.sv
`timescale 1ns/1ps
module sim_cls_lookup_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] cfg_entry_bits;
  logic       req_valid, req_ready;
  logic [7:0] req_tag;
  logic [3:0] req_rule_cnt;
  logic       lpm_cmd_valid, lpm_cmd_ready;
  logic [1:0] lpm_cmd_field, lpm_cmd_beat;
  logic [7:0] lpm_cmd_tag;
  logic       rule_cmd_valid, rule_cmd_ready;
  logic [3:0] rule_cmd_index;
  logic       rule_cmd_half;
  logic [7:0] rule_cmd_tag;
  logic       done_valid, done_ready;
  logic [7:0] done_tag;

  always #2 clk = ~clk;

  cls_lookup_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_entry_bits(cfg_entry_bits),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_rule_cnt(req_rule_cnt),
    .lpm_cmd_valid(lpm_cmd_valid), .lpm_cmd_ready(lpm_cmd_ready), .lpm_cmd_field(lpm_cmd_field),
    .lpm_cmd_beat(lpm_cmd_beat), .lpm_cmd_tag(lpm_cmd_tag),
    .rule_cmd_valid(rule_cmd_valid), .rule_cmd_ready(rule_cmd_ready),
    .rule_cmd_index(rule_cmd_index), .rule_cmd_half(rule_cmd_half), .rule_cmd_tag(rule_cmd_tag),
    .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag));

  int checks = 0, fails = 0, cyc = 0;
  int cur_nb = 1;
  bit bp_on = 0, lat_on = 0, int_on = 0;
  int exp_int = 0, n_stream = 0, prev_done = 0;
  int lpm_seen[256], rule_seen[256], fire_cyc[256], pkt_p[256];
  logic [11:0] exp_q[$];
  logic [7:0] next_tag = 8'd0;
  bit done_hold = 0, lpm_hold = 0, rule_hold = 0;
  logic [7:0] held_done_tag;
  logic [11:0] held_lpm, held_rule;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: samples at the falling edge, everything it sees fires at the next rising edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (done_hold) begin // R7
        chk(done_valid && done_tag == held_done_tag, "R7 done hold", done_tag, held_done_tag);
      end
      if (lpm_hold) begin  // R8
        chk(lpm_cmd_valid && {lpm_cmd_field, lpm_cmd_beat, lpm_cmd_tag} == held_lpm,
            "R8 lpm hold", {lpm_cmd_field, lpm_cmd_beat, lpm_cmd_tag}, held_lpm);
      end
      if (rule_hold) begin // R8
        chk(rule_cmd_valid && {rule_cmd_index, rule_cmd_half, rule_cmd_tag[6:0]} == held_rule,
            "R8 rule hold", {rule_cmd_index, rule_cmd_half, rule_cmd_tag[6:0]}, held_rule);
      end
      done_hold = done_valid && !done_ready;
      held_done_tag = done_tag;
      lpm_hold = lpm_cmd_valid && !lpm_cmd_ready;
      held_lpm = {lpm_cmd_field, lpm_cmd_beat, lpm_cmd_tag};
      rule_hold = rule_cmd_valid && !rule_cmd_ready;
      held_rule = {rule_cmd_index, rule_cmd_half, rule_cmd_tag[6:0]};

      if (req_valid && req_ready) begin
        lpm_seen[req_tag] = 0;
        rule_seen[req_tag] = 0;
        fire_cyc[req_tag] = cyc;
        pkt_p[req_tag] = req_rule_cnt;
        exp_q.push_back({req_rule_cnt, req_tag});
      end
      if (lpm_cmd_valid && lpm_cmd_ready) begin // R2
        int k;
        k = lpm_seen[lpm_cmd_tag];
        chk(int'(lpm_cmd_field) == k / cur_nb && int'(lpm_cmd_beat) == k % cur_nb,
            "R2 field/beat order", {lpm_cmd_field, lpm_cmd_beat}, ((k / cur_nb) << 2) | (k % cur_nb));
        lpm_seen[lpm_cmd_tag] = k + 1;
      end
      if (rule_cmd_valid && rule_cmd_ready) begin // R3
        int k;
        k = rule_seen[rule_cmd_tag];
        chk(int'(rule_cmd_index) == k / 2 && int'(rule_cmd_half) == k % 2 && k < 2 * pkt_p[rule_cmd_tag],
            "R3 rule order", {rule_cmd_index, rule_cmd_half}, k);
        rule_seen[rule_cmd_tag] = k + 1;
      end
      if (done_valid && done_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", done_tag, -1);
        end else begin
          logic [11:0] e;
          int p;
          e = exp_q.pop_front();
          p = int'(e[11:8]);
          chk(done_tag == e[7:0], "R6 done order/tag", done_tag, e[7:0]);
          chk(lpm_seen[done_tag] == 4 * cur_nb, "R1/R2 prefix burst count", lpm_seen[done_tag], 4 * cur_nb);
          chk(rule_seen[done_tag] == 2 * p, "R3 rule burst count", rule_seen[done_tag], 2 * p);
          if (lat_on) begin // R5
            chk(cyc - fire_cyc[done_tag] == 4 * cur_nb + 2 * p + 1, "R5 latency",
                cyc - fire_cyc[done_tag], 4 * cur_nb + 2 * p + 1);
          end
          if (int_on && n_stream >= 1) begin // R4
            chk(cyc - prev_done == exp_int, "R4 interval", cyc - prev_done, exp_int);
          end
          n_stream++;
          prev_done = cyc;
        end
      end
    end
  end

  // backpressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bp_on) begin
        lpm_cmd_ready  = ($urandom % 4) != 0;
        rule_cmd_ready = ($urandom % 3) != 0;
        done_ready     = ($urandom % 3) != 0;
      end
    end
  end

  task automatic send(input int p);
    req_valid = 1'b1;
    req_tag = next_tag;
    req_rule_cnt = 4'(p);
    next_tag = next_tag + 8'd1;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) begin
      @(posedge clk); #1;
    end
    repeat (3) begin @(posedge clk); #1; end
    chk(exp_q.size() == 0, "R6 all packets completed", exp_q.size(), 0);
  endtask

  task automatic do_reset(input int b);
    bp_on = 0; lat_on = 0; int_on = 0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    req_valid = 1'b0;
    lpm_cmd_ready = 1'b1; rule_cmd_ready = 1'b1; done_ready = 1'b1;
    cfg_entry_bits = 9'(b);
    cur_nb = (b + 71) / 72;
    exp_q.delete();
    repeat (3) begin @(posedge clk); #1; end
    @(negedge clk); // R9
    chk(!req_ready && !lpm_cmd_valid && !rule_cmd_valid && !done_valid, "R9 reset outputs",
        {req_ready, lpm_cmd_valid, rule_cmd_valid, done_valid}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R9 ready low after release", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(req_ready, "R9 ready high when idle", req_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic stream(input int n, input int p, input int interval);
    int_on = 1; exp_int = interval; n_stream = 0;
    for (int i = 0; i < n; i++) send(p);
    drain();
    int_on = 0;
  endtask

  task automatic single(input int p);
    lat_on = 1;
    send(p);
    drain();
    lat_on = 0;
  endtask

  initial begin
    rst_n = 1'b1;
    req_valid = 1'b0; req_tag = '0; req_rule_cnt = '0;
    lpm_cmd_ready = 1'b1; rule_cmd_ready = 1'b1; done_ready = 1'b1;
    cfg_entry_bits = 9'd72;
    #1 rst_n = 1'b0;

    do_reset(72);         // nb = 1
    single(3);            // R5: 4+6+1
    single(0);            // R5: p = 0 bypasses rule reads
    stream(6, 1, 4);      // R4: prefix phase bound
    stream(6, 6, 12);     // R4: rule phase bound

    do_reset(288);        // nb = 4
    stream(5, 8, 16);     // R4
    stream(5, 2, 16);     // R4
    @(posedge clk); #1;
    cfg_entry_bits = 9'd1; // R1: ignored after capture
    stream(5, 0, 16);
    single(1);

    do_reset(73);         // nb = 2
    stream(5, 8, 16);
    stream(5, 3, 8);
    single(0);            // R5: 9 cycles

    do_reset(151);        // nb = 3, random backpressure
    bp_on = 1;
    for (int i = 0; i < 40; i++) send($urandom % 9);
    drain();
    bp_on = 0;
    @(posedge clk); #1;
    lpm_cmd_ready = 1'b1; rule_cmd_ready = 1'b1; done_ready = 1'b1;

    do_reset(1);          // nb = 1, completion slot pressure
    bp_on = 1;
    for (int i = 0; i < 40; i++) send((i % 3 == 0) ? 0 : ($urandom % 9));
    drain();
    bp_on = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule